// File: doc/BRIEF.md
# Serial Flash Power-Down Release Responder

This block is the slave-side command logic of a serial flash device for a narrow set of operations. It puts the device into deep power-down, releases it again, and returns the device's one-byte electronic signature. A sticky byte-wide output mode can also be switched on and off. The serial pins (serial clock, active-low chip select, serial data in) are sampled with a faster system clock. Edges of the serial clock are found by comparing each sample with the one before. Opcode and address bits are taken on rising edges, and response data is launched on falling edges.

After the release/read-signature opcode and three dummy bytes, the signature is sent. In serial mode it comes out on the serial output, most significant bit first, one bit per serial clock. In byte-wide mode the whole byte goes out on an 8-bit bus every serial clock. Both outputs have an enable that a pad ring turns into real tri-state. A release from deep power-down passes through a timed wake state, measured in system clock cycles, before the device is in standby.

Top module: `sflash_wake_resp`

## Requirements
- R1: After reset, `pwr_state` is standby (2'b10), `par_mode` is 0, and `so_en` and `po_en` are both low.
- R2: While the opcode and the 24 dummy bits (32 rising edges of `sck` in total) are being received, `so_en` and `po_en` stay low. The first drive happens on the `sck` falling edge that follows the 32nd rising edge.
- R3: In serial mode, after the ABh opcode and the dummy bits, `so_d` carries the signature (SIG, default 17h) MSB first. One bit is launched per `sck` falling edge, with `so_en` high. While `cs_n` stays low, the byte repeats every eight falling edges.
- R4: In byte-wide mode, `po_d` carries the whole signature on every `sck` falling edge from the first output edge onward, with `po_en` high and `so_en` low.
- R5: Opcode 55h sets `par_mode` and 45h clears it, each on the 8th rising edge of a frame, in every power state. No other opcode, frame or power transition changes it.
- R6: Opcode B9h received in standby moves `pwr_state` to deep power-down (2'b00) when `cs_n` rises, provided all 8 opcode bits were received.
- R7: Opcode ABh received in deep power-down returns the signature. When `cs_n` then rises, `pwr_state` goes to wake (2'b01) and stays there for exactly RELEASE_CYC system clocks. After that it is standby.
- R8: In deep power-down, every opcode other than ABh, 55h and 45h produces no output and leaves `pwr_state` unchanged.
- R9: When `cs_n` goes high, the frame is aborted. Both enables are low one system clock later. A frame with fewer than 8 opcode bits has no effect, and the next frame starts decoding from its first bit.
- R10: In the wake state, ABh produces no output and does not shorten or restart the wake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset (power-up sequence) |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, MSB first |
| so_d | output | 1 | Serial output data |
| so_en | output | 1 | Serial output drive enable (low = high impedance) |
| po_d | output | 8 | Byte-wide output data |
| po_en | output | 1 | Byte-wide output drive enable (low = high impedance) |
| pwr_state | output | 2 | Power state: 00 deep power-down, 01 wake, 10 standby |
| par_mode | output | 1 | Byte-wide output mode flag |

## Verification
On every cycle the assertions check several invariants. Both outputs are quiet until the header has been counted. The two output paths are never on together. A high chip select silences both outputs. The serial enable stays up while the frame lasts. Power-state changes come only from the allowed source states, and the mode flag moves only on a completed opcode byte. The bench scenarios are the only place that can show the bit order and repetition of the signature, the exact length of the wake delay, and that ignored opcodes and truncated frames really leave the state alone.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  typedef enum logic [1:0] {
    PWR_DPD  = 2'b00,
    PWR_WAKE = 2'b01,
    PWR_STBY = 2'b10
  } pwr_e;

  localparam logic [7:0] OP_RELEASE = 8'hAB;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;
  localparam logic [7:0] OP_PAR_ON  = 8'h55;
  localparam logic [7:0] OP_PAR_OFF = 8'h45;

  // Number of rising edges before the response may start.
  function automatic int hdr_len(input int op_bits, input int dummy_bytes);
    return op_bits + dummy_bytes * 8;
  endfunction

  // Bit of the signature selected by a down-counting index.
  function automatic logic sig_bit(input logic [7:0] sig, input logic [2:0] idx);
    return sig[idx];
  endfunction

  // Timer preload giving exactly rel cycles in the wake state.
  function automatic int wake_load(input int rel);
    return (rel > 0) ? rel - 1 : 0;
  endfunction

endpackage

// File: rtl/sfw_spi_rx.sv
module sfw_spi_rx #(
  parameter int OP_BITS     = 8,
  parameter int DUMMY_BYTES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               si,
  output logic               sck_fall,
  output logic               cs_rise,
  output logic               op_done,
  output logic               op_valid,
  output logic [OP_BITS-1:0] opcode,
  output logic               hdr_done
);
  localparam int HDR_BITS = sfw_pkg::hdr_len(OP_BITS, DUMMY_BYTES);
  localparam int CW       = $clog2(HDR_BITS + 1);

  logic               sck_q, cs_q;
  logic [OP_BITS-1:0] sh;
  logic [CW-1:0]      bit_cnt;
  logic               sck_rise;

  // Named edge events
  assign sck_rise = !cs_n && sck && !sck_q;
  assign sck_fall = !cs_n && !sck && sck_q;
  assign cs_rise  = cs_n && !cs_q;
  assign hdr_done = (bit_cnt == CW'(HDR_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      sh       <= '0;
      bit_cnt  <= '0;
      op_valid <= 1'b0;
      op_done  <= 1'b0;
      opcode   <= '0;
    end else begin
      sck_q   <= sck;
      cs_q    <= cs_n;
      op_done <= 1'b0;
      if (cs_n) begin
        bit_cnt  <= '0;
        op_valid <= 1'b0;
        sh       <= '0;
      end else if (sck_rise) begin
        sh <= {sh[OP_BITS-2:0], si};
        if (bit_cnt != CW'(HDR_BITS)) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CW'(OP_BITS - 1)) begin
          opcode   <= {sh[OP_BITS-2:0], si};
          op_valid <= 1'b1;
          op_done  <= 1'b1;
        end
      end
    end
  end

  AST_OPDONE_AT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (bit_cnt == CW'(OP_BITS)));  // R5
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == '0 && !op_valid));  // R9

endmodule

// File: rtl/sfw_pwr_ctrl.sv
module sfw_pwr_ctrl #(
  parameter int RELEASE_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rise,
  input  logic             op_done,
  input  logic             op_valid,
  input  logic [7:0]       opcode,
  output sfw_pkg::pwr_e    state,
  output logic             par_mode,
  output logic             rd_allow
);
  import sfw_pkg::*;

  localparam int TW = $clog2(RELEASE_CYC + 1);

  logic [TW-1:0] timer;
  logic ev_par_on, ev_par_off, ev_sleep, ev_release, ev_wake_end;

  assign ev_par_on   = op_done && (opcode == OP_PAR_ON);
  assign ev_par_off  = op_done && (opcode == OP_PAR_OFF);
  assign ev_sleep    = cs_rise && op_valid && (opcode == OP_SLEEP)   && (state == PWR_STBY);
  assign ev_release  = cs_rise && op_valid && (opcode == OP_RELEASE) && (state == PWR_DPD);
  assign ev_wake_end = (state == PWR_WAKE) && (timer == '0);
  assign rd_allow    = (state != PWR_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_mode <= 1'b0;
    end else if (ev_par_on) begin
      par_mode <= 1'b1;
    end else if (ev_par_off) begin
      par_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PWR_STBY;
      timer <= '0;
    end else begin
      unique case (state)
        PWR_STBY: if (ev_sleep) state <= PWR_DPD;
        PWR_DPD: begin
          if (ev_release) begin
            state <= PWR_WAKE;
            timer <= TW'(wake_load(RELEASE_CYC));
          end
        end
        PWR_WAKE: begin
          if (ev_wake_end) state <= PWR_STBY;
          else             timer <= timer - 1'b1;
        end
        default: state <= PWR_STBY;
      endcase
    end
  end

  AST_DPD_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_DPD) |=> (state != PWR_STBY));  // R8
  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_WAKE && $past(state) != PWR_WAKE) |-> ($past(state) == PWR_DPD));  // R7
  AST_SLEEP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_DPD && $past(state) != PWR_DPD) |-> ($past(state) == PWR_STBY));  // R6
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode != $past(par_mode)) |-> $past(op_done));  // R5

endmodule

// File: rtl/sfw_resp_drv.sv
module sfw_resp_drv #(
  parameter logic [7:0] SIG = 8'h17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck_fall,
  input  logic       hdr_done,
  input  logic       op_done,
  input  logic [7:0] opcode,
  input  logic       rd_allow,
  input  logic       par_mode,
  output logic       so_d,
  output logic       so_en,
  output logic [7:0] po_d,
  output logic       po_en
);
  import sfw_pkg::*;

  logic       armed;
  logic [2:0] idx;
  logic       launch;

  // Response launch event: armed read, header done, falling edge
  assign launch = armed && hdr_done && sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      idx   <= 3'd7;
      so_d  <= 1'b0;
      so_en <= 1'b0;
      po_d  <= '0;
      po_en <= 1'b0;
    end else if (cs_n) begin
      armed <= 1'b0;
      idx   <= 3'd7;
      so_d  <= 1'b0;
      so_en <= 1'b0;
      po_d  <= '0;
      po_en <= 1'b0;
    end else begin
      if (op_done && (opcode == OP_RELEASE) && rd_allow) armed <= 1'b1;
      if (launch) begin
        if (par_mode) begin
          po_en <= 1'b1;
          po_d  <= SIG;
        end else begin
          so_en <= 1'b1;
          so_d  <= sig_bit(SIG, idx);
          idx   <= idx - 1'b1;
        end
      end
    end
  end

  AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_done |-> !(so_en || po_en));  // R2
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !(so_en && po_en));  // R4
  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !(so_en || po_en));  // R9
  AST_SO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (so_en && !cs_n) |=> so_en);  // R3
  AST_SO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    so_en |-> !par_mode);  // R4

endmodule

// File: rtl/sflash_wake_resp.sv
module sflash_wake_resp #(
  parameter int         RELEASE_CYC = 64,
  parameter logic [7:0] SIG         = 8'h17,
  parameter int         DUMMY_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       so_d,
  output logic       so_en,
  output logic [7:0] po_d,
  output logic       po_en,
  output logic [1:0] pwr_state,
  output logic       par_mode
);
  import sfw_pkg::*;

  localparam int OP_BITS = 8;

  logic               sck_fall, cs_rise, op_done, op_valid, hdr_done, rd_allow;
  logic [OP_BITS-1:0] opcode;
  pwr_e               state;

  sfw_spi_rx #(.OP_BITS(OP_BITS), .DUMMY_BYTES(DUMMY_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .sck_fall(sck_fall), .cs_rise(cs_rise), .op_done(op_done),
    .op_valid(op_valid), .opcode(opcode), .hdr_done(hdr_done)
  );

  sfw_pwr_ctrl #(.RELEASE_CYC(RELEASE_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .op_done(op_done),
    .op_valid(op_valid), .opcode(opcode), .state(state),
    .par_mode(par_mode), .rd_allow(rd_allow)
  );

  sfw_resp_drv #(.SIG(SIG)) u_drv (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
    .hdr_done(hdr_done), .op_done(op_done), .opcode(opcode),
    .rd_allow(rd_allow), .par_mode(par_mode), .so_d(so_d), .so_en(so_en),
    .po_d(po_d), .po_en(po_en)
  );

  assign pwr_state = state;

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (pwr_state == 2'b10 || !rst_n));  // R1

endmodule

// File: tb/sflash_wake_resp_tb.sv
module sflash_wake_resp_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         REL        = 300;
  localparam logic [7:0] SIG        = 8'h17;
  localparam logic [1:0] ST_DPD = 2'b00, ST_WAKE = 2'b01, ST_STBY = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so_d, so_en, po_en, par_mode;
  logic [7:0] po_d;
  logic [1:0] pwr_state;

  int nchk = 0, nfail = 0, hper = 1;
  logic [1:0] exp_state = ST_STBY;
  bit exp_par = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_wake_resp #(.RELEASE_CYC(REL)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so_d(so_d), .so_en(so_en), .po_d(po_d), .po_en(po_en),
    .pwr_state(pwr_state), .par_mode(par_mode)
  );

  function automatic bit exp_ser_bit(input int j);
    return bit'((SIG >> (7 - (j % 8))) & 8'h01);
  endfunction

  function automatic int exp_mode(input logic [7:0] op, input int nbits);
    if (op == 8'hAB && nbits >= 32 && exp_state != ST_WAKE) return exp_par ? 2 : 1;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic run_frame(input logic [7:0] op, input int nbits, input int mode,
                           input string tag0);
    bit early = 0, bad = 0;
    cs_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      si  = (k < 8) ? op[7-k] : 1'($urandom % 2);
      sck = 1'b1;
      nwait(hper);
      sck = 1'b0;
      @(negedge clk);
      if (k < 31) begin
        if (so_en || po_en) early = 1;
      end else begin
        int j = k - 31;
        case (mode)
          1: if (!so_en || po_en || so_d != exp_ser_bit(j)) bad = 1;
          2: if (!po_en || so_en || po_d != SIG) bad = 1;
          default: if (so_en || po_en) bad = 1;
        endcase
      end
      nwait(hper - 1);
    end
    check(!early, "R2 header quiet", int'(early), 0);
    if (nbits >= 32)
      check(!bad, (mode == 1) ? "R3 serial signature" :
                  (mode == 2) ? "R4 byte-wide signature" : tag0, int'(bad), 0);
    cs_n = 1'b1;
    @(negedge clk);
    check(!(so_en || po_en), "R9 outputs off after cs_n", {so_en, po_en}, 0);
  endtask

  task automatic wait_wake(input bit exact);
    int cnt = 0;
    while (pwr_state == ST_WAKE && cnt < 10 * REL) begin
      cnt++;
      @(negedge clk);
    end
    if (exact) check(cnt == REL, "R7 wake length", cnt, REL);
    check(pwr_state == ST_STBY, "R7 standby after wake", pwr_state, ST_STBY);
    exp_state = ST_STBY;
  endtask

  task automatic do_cmd(input logic [7:0] op, input int nbits, input bit wait_w,
                        input string tag);
    int mode = exp_mode(op, nbits);
    bit rel = 0;
    run_frame(op, nbits, mode, tag);
    if (nbits >= 8) begin
      if (op == 8'h55) exp_par = 1'b1;
      if (op == 8'h45) exp_par = 1'b0;
      if (op == 8'hB9 && exp_state == ST_STBY) exp_state = ST_DPD;
      if (op == 8'hAB && exp_state == ST_DPD) begin exp_state = ST_WAKE; rel = 1; end
    end
    check(par_mode == exp_par, "R5 mode flag", par_mode, exp_par);
    check(pwr_state == exp_state, tag, pwr_state, exp_state);
    if (rel && wait_w) wait_wake(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    nwait(5);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwr_state == ST_STBY, "R1 reset state", pwr_state, ST_STBY);
    check(par_mode == 1'b0, "R1 reset mode", par_mode, 0);
    check(!(so_en || po_en), "R1 reset enables", {so_en, po_en}, 0);

    // R3: serial read in standby, two repeats, different clock rates
    hper = 1; do_cmd(8'hAB, 48, 1, "R3 state");
    hper = 3; do_cmd(8'hAB, 40, 1, "R3 state");
    // R9: abort mid-output, then full frame decodes from bit 0
    hper = 2; do_cmd(8'hAB, 35, 1, "R9 state");
    do_cmd(8'hAB, 40, 1, "R9 state");
    // R9: truncated sleep opcode has no effect
    do_cmd(8'hB9, 7, 1, "R9 truncated opcode");
    // R6: sleep
    do_cmd(8'hB9, 8, 1, "R6 enter deep power-down");
    // R8: other opcodes ignored in deep power-down
    do_cmd(8'h03, 40, 1, "R8 ignored opcode");
    do_cmd(8'h9F, 44, 1, "R8 ignored opcode");
    do_cmd(8'hB9, 40, 1, "R8 ignored opcode");
    // R5: mode enter accepted in deep power-down
    do_cmd(8'h55, 8, 1, "R5 state");
    // R4 + R7: byte-wide release with exact wake length
    hper = 1; do_cmd(8'hAB, 37, 1, "R7 wake entry");
    // R5: sticky across sleep
    do_cmd(8'hB9, 16, 1, "R6 enter deep power-down");
    do_cmd(8'h45, 8, 1, "R5 state");
    // R10: read during wake gives nothing and keeps the delay
    do_cmd(8'hAB, 8, 0, "R7 wake entry");
    do_cmd(8'hAB, 40, 0, "R10 wake ignores read");
    wait_wake(1'b0);

    // Constrained random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] op;
      int sel = $urandom % 5;
      int nb  = 4 + ($urandom % 53);
      hper = 1 + ($urandom % 3);
      case (sel)
        0: op = 8'hAB;
        1: op = 8'hB9;
        2: op = 8'h55;
        3: op = 8'h45;
        default: begin
          op = 8'($urandom);
          if (op == 8'hAB || op == 8'hB9 || op == 8'h55 || op == 8'h45) op = 8'h0B;
        end
      endcase
      do_cmd(op, nb, 1, "R8 random state");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule